// File: doc/BRIEF.md
# Deferred Fault Token Tracker

This block keeps one poison bit per architectural register so that loads can be hoisted above branches without raising a fault too early. When a speculative load would have faulted, the fault is not raised. The load's destination register is marked poisoned instead. Any instruction that reads a poisoned register passes the poison on to the register it writes. A later explicit check on a register turns a poisoned state into a request to branch to recovery code. A check on a clean register does nothing.

The block sits beside the register file and sees three streams. The first is load completions, each carrying a speculative flag and a fault flag. The second is instruction issue, with up to two source specifiers and one destination. The third is checks, each naming one register and carrying a recovery target index. Data values, the memory access itself and delivery of the exception belong to the surrounding pipeline.

Top module: `poison_tracker`

## Requirements
- R1: A load completion with `ld_spec`=1 and `ld_fault`=1 sets the poison bit of `ld_dst`.
- R2: Any other load completion clears the poison bit of `ld_dst`. This covers a speculative load without a fault and any load with `ld_spec`=0.
- R3: An issued instruction sets the poison bit of `is_dst` when at least one of its used sources is poisoned. A source is used when its enable bit is 1. The test is a logical OR of the two used sources.
- R4: An issued instruction clears the poison bit of `is_dst` when every used source is clean, or when it uses no source.
- R5: A check on a clean register leaves `rcv_req` at 0 in the cycle after the check.
- R6: A check on a poisoned register drives `rcv_req`=1 in the cycle after the check. In that same cycle, `rcv_tgt` equals the `ck_tgt` that came with the check.
- R7: When a load completion and an issued instruction write the same register in the same cycle, the load completion decides that register's poison bit.
- R8: Checks and issue source reads use the poison state as it stood before the current cycle's updates. An update becomes visible to a check or an issue one cycle later.
- R9: Reset clears every poison bit, and `rcv_req` is 0 while reset is applied.
- R10: A register that is not the destination of a load or an issue in a cycle keeps its poison bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| ld_valid | input | 1 | A load completes this cycle |
| ld_spec | input | 1 | The completing load was speculative |
| ld_fault | input | 1 | The completing load would have faulted |
| ld_dst | input | 7 | Destination register of the load |
| is_valid | input | 1 | An instruction issues this cycle |
| is_use_a | input | 1 | Source A is read |
| is_src_a | input | 7 | Source A register |
| is_use_b | input | 1 | Source B is read |
| is_src_b | input | 7 | Source B register |
| is_dst | input | 7 | Destination register of the instruction |
| ck_valid | input | 1 | A check is made this cycle |
| ck_reg | input | 7 | Register that is checked |
| ck_tgt | input | 16 | Recovery target index for this check |
| rcv_req | output | 1 | Branch-to-recovery request, one cycle after a check that finds poison |
| rcv_tgt | output | 16 | Recovery target of the most recent check that found poison |

## Verification
Every poison update happens at the clock edge that samples the load or issue. The first check or issue that can see the update is the one sampled at the next edge. A check's result appears on `rcv_req` and `rcv_tgt` right after the edge that samples it, so it is due one cycle after the check. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge. It compares the outputs at the next falling edge, against values it predicted from the model state before that edge's updates.

// File: rtl/pt_pkg.sv
package pt_pkg;
  // Source of a register's next poison value within one cycle
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_ISSUE = 2'd1,
    UPD_LOAD  = 2'd2
  } upd_sel_e;
endpackage

// File: rtl/pt_src_merge.sv
module pt_src_merge #(
  parameter int REG_W = 7,
  localparam int NREG = 1 << REG_W
) (
  input  logic [NREG-1:0]  tok_i,
  input  logic             use_a_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic             use_b_i,
  input  logic [REG_W-1:0] src_b_i,
  output logic             poison_o
);
  logic a_bad;
  logic b_bad;

  always_comb begin
    a_bad    = use_a_i & tok_i[src_a_i];
    b_bad    = use_b_i & tok_i[src_b_i];
    poison_o = a_bad | b_bad;
  end
endmodule

// File: rtl/pt_token_array.sv
module pt_token_array
  import pt_pkg::*;
#(
  parameter int REG_W = 7,
  localparam int NREG = 1 << REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we_i,
  input  logic             ld_poison_i,
  input  logic [REG_W-1:0] ld_dst_i,
  input  logic             is_we_i,
  input  logic             is_poison_i,
  input  logic [REG_W-1:0] is_dst_i,
  output logic [NREG-1:0]  tok_o
);
  logic [NREG-1:0] tok_q;
  logic [NREG-1:0] tok_d;
  logic [NREG-1:0] tok_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [REG_W-1:0] IDX = REG_W'(g);
    upd_sel_e sel;

    always_comb begin
      if (ld_we_i && ld_dst_i == IDX)      sel = UPD_LOAD;
      else if (is_we_i && is_dst_i == IDX) sel = UPD_ISSUE;
      else                                 sel = UPD_HOLD;
      tok_en[g] = (sel != UPD_HOLD);
      case (sel)
        UPD_LOAD:  tok_d[g] = ld_poison_i;
        UPD_ISSUE: tok_d[g] = is_poison_i;
        default:   tok_d[g] = tok_q[g];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tok_q[g] <= 1'b0;
      else if (tok_en[g]) tok_q[g] <= tok_d[g];
    end
  end

  assign tok_o = tok_q;

  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we_i && ld_poison_i) |=> tok_q[$past(ld_dst_i)]); // R1
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we_i && !ld_poison_i) |=> !tok_q[$past(ld_dst_i)]); // R2
  AST_ISSUE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_we_i && !(ld_we_i && ld_dst_i == is_dst_i)) |=> (tok_q[$past(is_dst_i)] == $past(is_poison_i))); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_we_i && ld_we_i && ld_dst_i == is_dst_i) |=> (tok_q[$past(ld_dst_i)] == $past(ld_poison_i))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_we_i && !is_we_i) |=> $stable(tok_q)); // R10
endmodule

// File: rtl/pt_check_stage.sv
module pt_check_stage #(
  parameter int REG_W = 7,
  parameter int TGT_W = 16,
  localparam int NREG = 1 << REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  tok_i,
  input  logic             ck_valid_i,
  input  logic [REG_W-1:0] ck_reg_i,
  input  logic [TGT_W-1:0] ck_tgt_i,
  output logic             rcv_req_o,
  output logic [TGT_W-1:0] rcv_tgt_o
);
  logic             hit;
  logic             req_d;
  logic             req_q;
  logic [TGT_W-1:0] tgt_q;
  logic             tgt_en;

  always_comb begin
    hit    = ck_valid_i & tok_i[ck_reg_i];
    req_d  = hit;
    tgt_en = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= ck_tgt_i;
  end

  assign rcv_req_o = req_q;
  assign rcv_tgt_o = tgt_q;

  AST_CLEAN_CHECK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid_i && !tok_i[ck_reg_i]) |=> !rcv_req_o); // R5
  AST_POISON_CHECK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_valid_i && tok_i[ck_reg_i]) |=> (rcv_req_o && rcv_tgt_o == $past(ck_tgt_i))); // R6
  AST_NO_CHECK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_valid_i |=> !rcv_req_o); // R5
endmodule

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int REG_W = 7,
  parameter int TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_spec,
  input  logic             ld_fault,
  input  logic [REG_W-1:0] ld_dst,
  input  logic             is_valid,
  input  logic             is_use_a,
  input  logic [REG_W-1:0] is_src_a,
  input  logic             is_use_b,
  input  logic [REG_W-1:0] is_src_b,
  input  logic [REG_W-1:0] is_dst,
  input  logic             ck_valid,
  input  logic [REG_W-1:0] ck_reg,
  input  logic [TGT_W-1:0] ck_tgt,
  output logic             rcv_req,
  output logic [TGT_W-1:0] rcv_tgt
);
  localparam int NREG = 1 << REG_W;

  logic [1:0]      rst_sync_q;
  logic            rst_in_n;
  logic [NREG-1:0] tok;
  logic            is_poison;
  logic            ld_poison;

  // Reset asserts at once, releases after two rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  assign ld_poison = ld_spec & ld_fault;

  pt_src_merge #(.REG_W(REG_W)) u_merge (
    .tok_i    (tok),
    .use_a_i  (is_use_a),
    .src_a_i  (is_src_a),
    .use_b_i  (is_use_b),
    .src_b_i  (is_src_b),
    .poison_o (is_poison)
  );

  pt_token_array #(.REG_W(REG_W)) u_array (
    .clk         (clk),
    .rst_n       (rst_in_n),
    .ld_we_i     (ld_valid),
    .ld_poison_i (ld_poison),
    .ld_dst_i    (ld_dst),
    .is_we_i     (is_valid),
    .is_poison_i (is_poison),
    .is_dst_i    (is_dst),
    .tok_o       (tok)
  );

  pt_check_stage #(.REG_W(REG_W), .TGT_W(TGT_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_in_n),
    .tok_i      (tok),
    .ck_valid_i (ck_valid),
    .ck_reg_i   (ck_reg),
    .ck_tgt_i   (ck_tgt),
    .rcv_req_o  (rcv_req),
    .rcv_tgt_o  (rcv_tgt)
  );

  AST_ISSUE_OR_SOURCES: assert property (@(posedge clk) disable iff (!rst_in_n)
    (is_valid && !(ld_valid && ld_dst == is_dst) && is_use_a && tok[is_src_a]) |=> tok[$past(is_dst)]); // R3
  AST_ISSUE_NO_SOURCES: assert property (@(posedge clk) disable iff (!rst_in_n)
    (is_valid && !(ld_valid && ld_dst == is_dst) && !is_use_a && !is_use_b) |=> !tok[$past(is_dst)]); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_in_n |-> !rcv_req); // R9
endmodule

// File: tb/sim_poison_tracker.sv
module sim_poison_tracker;
  localparam int REG_W = 7;
  localparam int TGT_W = 16;
  localparam int NREG  = 1 << REG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, ld_spec = 0, ld_fault = 0;
  logic [REG_W-1:0] ld_dst = '0;
  logic is_valid = 0, is_use_a = 0, is_use_b = 0;
  logic [REG_W-1:0] is_src_a = '0, is_src_b = '0, is_dst = '0;
  logic ck_valid = 0;
  logic [REG_W-1:0] ck_reg = '0;
  logic [TGT_W-1:0] ck_tgt = '0;
  logic rcv_req;
  logic [TGT_W-1:0] rcv_tgt;

  int n_vec = 0;
  int n_bad = 0;
  bit model [NREG];
  bit exp_req;
  logic [TGT_W-1:0] exp_tgt = '0;
  string tag = "R9";

  always #2 clk = ~clk;

  poison_tracker #(.REG_W(REG_W), .TGT_W(TGT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_spec(ld_spec), .ld_fault(ld_fault), .ld_dst(ld_dst),
    .is_valid(is_valid), .is_use_a(is_use_a), .is_src_a(is_src_a),
    .is_use_b(is_use_b), .is_src_b(is_src_b), .is_dst(is_dst),
    .ck_valid(ck_valid), .ck_reg(ck_reg), .ck_tgt(ck_tgt),
    .rcv_req(rcv_req), .rcv_tgt(rcv_tgt)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // One clock: predict from pre-edge model, advance model, compare after edge
  task automatic cycle();
    bit ipois;
    exp_req = ck_valid && model[ck_reg];
    if (exp_req) exp_tgt = ck_tgt;
    ipois = (is_use_a && model[is_src_a]) || (is_use_b && model[is_src_b]);
    @(posedge clk);
    if (is_valid) model[is_dst] = ipois;
    if (ld_valid) model[ld_dst] = ld_spec && ld_fault;
    @(negedge clk);
    n_vec++;
    if (rcv_req !== exp_req) begin
      n_bad++;
      $display("FAIL %s rcv_req actual %0b expected %0b", tag, rcv_req, exp_req);
    end else if (exp_req && rcv_tgt !== exp_tgt) begin
      n_bad++;
      $display("FAIL %s rcv_tgt actual %0h expected %0h", tag, rcv_tgt, exp_tgt);
    end
    ld_valid = 0; is_valid = 0; ck_valid = 0;
  endtask

  task automatic do_load(input logic [REG_W-1:0] r, input bit s, input bit f);
    ld_valid = 1; ld_dst = r; ld_spec = s; ld_fault = f;
  endtask

  task automatic do_issue(input logic [REG_W-1:0] d, input bit ua, input logic [REG_W-1:0] a,
                          input bit ub, input logic [REG_W-1:0] b);
    is_valid = 1; is_dst = d; is_use_a = ua; is_src_a = a; is_use_b = ub; is_src_b = b;
  endtask

  task automatic do_check(input logic [REG_W-1:0] r, input logic [TGT_W-1:0] t);
    ck_valid = 1; ck_reg = r; ck_tgt = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 0;
    // R9: quiet during reset, with a check asserted
    repeat (2) @(negedge clk);
    do_check(7'd3, 16'h1);
    @(negedge clk);
    n_vec++;
    if (rcv_req !== 1'b0) begin n_bad++; $display("FAIL R9 rcv_req in reset actual %0b expected 0", rcv_req); end
    ck_valid = 0;
    rst_n = 1;
    repeat (4) @(negedge clk);

    tag = "R9";
    for (int i = 0; i < NREG; i++) begin do_check(REG_W'(i), 16'h5000); cycle(); end

    tag = "R1"; do_load(7'd10, 1, 1); cycle();
    do_check(7'd10, 16'hA001); cycle();
    tag = "R2"; do_load(7'd10, 1, 0); cycle();
    tag = "R5"; do_check(7'd10, 16'hA002); cycle();
    tag = "R1"; do_load(7'd11, 1, 1); cycle();
    tag = "R2"; do_load(7'd11, 0, 1); cycle();
    do_check(7'd11, 16'hA003); cycle();
    tag = "R3"; do_load(7'd20, 1, 1); cycle();
    do_issue(7'd21, 1, 7'd5, 1, 7'd20); cycle();
    tag = "R6"; do_check(7'd21, 16'hBEEF); cycle();
    tag = "R3"; do_issue(7'd22, 1, 7'd21, 0, 7'd0); cycle();
    do_check(7'd22, 16'hC0DE); cycle();
    tag = "R4"; do_issue(7'd21, 1, 7'd5, 0, 7'd20); cycle();
    do_check(7'd21, 16'hC0D1); cycle();
    do_issue(7'd22, 0, 7'd20, 0, 7'd20); cycle();
    do_check(7'd22, 16'hC0D2); cycle();
    tag = "R7"; do_load(7'd30, 1, 0); do_issue(7'd30, 1, 7'd20, 0, 7'd0); cycle();
    do_check(7'd30, 16'hD001); cycle();
    do_load(7'd31, 1, 1); do_issue(7'd31, 0, 7'd0, 0, 7'd0); cycle();
    do_check(7'd31, 16'hD002); cycle();
    tag = "R8"; do_load(7'd40, 1, 1); do_check(7'd40, 16'hE001); cycle();
    do_check(7'd40, 16'hE002); cycle();
    do_load(7'd41, 1, 1); do_issue(7'd42, 1, 7'd41, 0, 7'd0); cycle();
    do_check(7'd42, 16'hE003); cycle();
    tag = "R10"; do_check(7'd127, 16'hF00F); cycle();
    do_check(7'd20, 16'hF010); cycle();

    tag = "R10";
    for (int k = 0; k < 4000; k++) begin
      logic [REG_W-1:0] pick [5];
      for (int j = 0; j < 5; j++) begin
        int v;
        v = $urandom_range(0, 8);
        pick[j] = (v == 8) ? 7'd127 : REG_W'(v);
      end
      if ($urandom_range(0, 2) != 0) do_load(pick[0], 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 2) != 0)
        do_issue(pick[1], 1'($urandom), pick[2], 1'($urandom), pick[3]);
      if ($urandom_range(0, 3) != 0) do_check(pick[4], 16'($urandom));
      cycle();
    end
    finish_run();
  end
endmodule